// File: doc/BRIEF.md
# Biphase Serial Line Transmitter

This block serializes parallel words and sends them as biphase (Manchester-style) line code. Words arrive one at a time over a valid/ready stream. Each word is shifted out most significant bit first. Every bit time is split into four quarters by a clock enable, `qtick`, that runs at four times the bit rate. The level changes at mid-bit, which makes the line self-clocking.

There are three outputs. `line_out` is the polarity-inverted biphase waveform. `line_dly` is the same waveform one quarter bit later. `tx_active` enables an external line driver. It rises with the first quarter on `line_out` and falls only after `line_dly` has shown its final quarter, so it covers both data outputs. When no word is in flight, both data outputs rest high.

Back-pressure rules: `in_ready` is only ever high in a cycle where `qtick` is high. A word transfers at a rising clock edge where `in_valid` and `in_ready` are both high. After raising `in_valid`, the source keeps `in_valid` and `in_data` steady until that transfer. A source that holds the next word valid during the final quarter of the current word gets it sent with no gap.

Top module: `biphase_tx`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `tx_active` is 0 and `line_out` and `line_dly` are 1.
- R2: `in_ready` is 1 exactly in cycles where `qtick` is 1 and either no word is being sent or the fourth quarter of the word's last bit is on `line_out`. In every other cycle it is 0.
- R3: For a data bit b, `line_out` is ~b during quarters 1 and 2 of the bit and b during quarters 3 and 4. Before inversion, a 1 is high then low and a 0 is low then high.
- R4: Bits leave most significant first. Each bit lasts exactly four `qtick` periods. The first quarter starts in the cycle after the accepting edge.
- R5: At every edge where `qtick` is 1, `line_dly` takes the value `line_out` held just before that edge, so `line_dly` lags by one quarter bit.
- R6: `tx_active` rises only in the cycle after a transfer. It stays 1 while `line_out` carries data and for one quarter after the last data quarter, then drops to 0.
- R7: A word accepted during the last quarter of the previous word starts on the next quarter, with no idle quarter between the two words.
- R8: While `tx_active` is 0, `line_out` and `line_dly` are both 1.
- R9: An edge with `qtick` low changes none of `line_out`, `line_dly`, `tx_active`.
- R10: `in_data` has no effect while `in_valid` is 0. The outputs stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| qtick | input | 1 | Quarter-bit clock enable |
| in_data | input | WORD_W | Word to send, MSB first |
| in_valid | input | 1 | Source has a word |
| in_ready | output | 1 | Block takes the word at this edge |
| line_out | output | 1 | Inverted biphase serial output |
| line_dly | output | 1 | `line_out` delayed one quarter bit |
| tx_active | output | 1 | High while either data output carries data |

## Verification
The first quarter of a word appears on `line_out` in the cycle after its accepting edge. Each later quarter begins after the next `qtick` edge. `line_dly` shows a quarter one `qtick` edge after `line_out` does. `tx_active` falls at the `qtick` edge that ends the delayed copy of the final quarter. The scoreboard queues the four expected quarters of each bit when a transfer edge has passed. It compares at the falling edge of each `qtick`-high cycle, when the quarter on display is complete. The delayed output is checked against the quarter sampled one `qtick` earlier. Falling edges after a cycle with `qtick` low confirm that nothing moved.

// File: rtl/biphase_pkg.sv
package biphase_pkg;
  typedef logic [1:0] phase_t;

  localparam phase_t PH_FIRST = 2'd0;
  localparam phase_t PH_LAST  = 2'd3;

  // Raw (uninverted) level for a bit: value in first half, complement in second.
  function automatic logic raw_level(input logic b, input phase_t ph);
    return ph[1] ? ~b : b;
  endfunction
endpackage

// File: rtl/bp_shifter.sv
module bp_shifter
  import biphase_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              qtick,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              busy,
  output logic              cur_bit,
  output phase_t            phase
);
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_idx;
  logic              on_last;
  logic              take;

  assign on_last  = busy && (phase == PH_LAST) && (bit_idx == LAST_IDX);
  assign in_ready = qtick && (!busy || on_last);
  assign take     = in_valid && in_ready;
  assign cur_bit  = shreg[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      shreg   <= '0;
      bit_idx <= '0;
      phase   <= PH_FIRST;
    end else if (qtick) begin
      if (take) begin
        shreg   <= in_data;
        bit_idx <= '0;
        phase   <= PH_FIRST;
        busy    <= 1'b1;
      end else if (busy) begin
        phase <= phase + 2'd1;
        if (phase == PH_LAST) begin
          if (on_last) begin
            busy <= 1'b0;
          end else begin
            shreg   <= shreg << 1;
            bit_idx <= bit_idx + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/bp_encoder.sv
module bp_encoder
  import biphase_pkg::*;
#(
  parameter bit INVERT_OUT = 1'b1
) (
  input  logic   busy,
  input  logic   cur_bit,
  input  phase_t phase,
  output logic   line_out
);
  // Idle rests at the inverted form of a raw low level.
  always_comb begin
    if (busy) line_out = raw_level(cur_bit, phase) ^ INVERT_OUT;
    else      line_out = INVERT_OUT;
  end
endmodule

// File: rtl/bp_delay.sv
module bp_delay #(
  parameter bit IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic qtick,
  input  logic line_in,
  input  logic busy_in,
  output logic line_dly,
  output logic tx_active
);
  logic tail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_dly <= IDLE_LVL;
      tail_q   <= 1'b0;
    end else if (qtick) begin
      line_dly <= line_in;
      tail_q   <= busy_in;
    end
  end

  assign tx_active = busy_in | tail_q;
endmodule

// File: rtl/biphase_tx.sv
module biphase_tx
  import biphase_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter bit INVERT_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              qtick,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              line_out,
  output logic              line_dly,
  output logic              tx_active
);
  logic   busy;
  logic   cur_bit;
  phase_t phase;

  bp_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .qtick(qtick),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .busy(busy), .cur_bit(cur_bit), .phase(phase)
  );

  bp_encoder #(.INVERT_OUT(INVERT_OUT)) u_enc (
    .busy(busy), .cur_bit(cur_bit), .phase(phase), .line_out(line_out)
  );

  bp_delay #(.IDLE_LVL(INVERT_OUT)) u_dly (
    .clk(clk), .rst(rst), .qtick(qtick),
    .line_in(line_out), .busy_in(busy),
    .line_dly(line_dly), .tx_active(tx_active)
  );
endmodule

// File: rtl/biphase_tx_chk.sv
module biphase_tx_chk (
  input logic clk,
  input logic rst,
  input logic qtick,
  input logic in_valid,
  input logic in_ready,
  input logic line_out,
  input logic line_dly,
  input logic tx_active
);
  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> qtick); // R2
  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (qtick && !tx_active) |-> in_ready); // R2
  AST_DLY_LAGS_QUARTER: assert property (@(posedge clk) disable iff (rst)
    qtick |=> (line_dly == $past(line_out))); // R5
  AST_ACTIVE_AFTER_XFER: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_active) |-> $past(in_valid && in_ready)); // R6
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !tx_active |-> (line_out && line_dly)); // R8
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !qtick |=> ($stable(line_out) && $stable(line_dly) && $stable(tx_active))); // R9
endmodule

bind biphase_tx biphase_tx_chk u_chk (
  .clk(clk), .rst(rst), .qtick(qtick), .in_valid(in_valid),
  .in_ready(in_ready), .line_out(line_out), .line_dly(line_dly),
  .tx_active(tx_active)
);

// File: tb/sim_biphase_tx.sv
`timescale 1ns/1ps
module sim_biphase_tx;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         qtick = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_valid = 1'b0;
  logic         in_ready, line_out, line_dly, tx_active;

  int errors = 0;
  int checks = 0;
  int tick_per = 4;
  int tick_cnt = 0;
  int last_acc_q = 0;
  logic exp_q[$];

  bit   mon_en = 0, have_prev = 0, prev_tick = 0;
  logic p_out, p_dly, p_act;
  logic last_out = 1'b1, prev_data = 1'b0, cur_data, e;

  always #2 clk = ~clk; // 250 MHz

  biphase_tx #(.WORD_W(W)) u0 (
    .clk(clk), .rst(rst), .qtick(qtick), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .line_out(line_out),
    .line_dly(line_dly), .tx_active(tx_active)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (tick_cnt >= tick_per - 1) begin qtick = 1'b1; tick_cnt = 0; end
    else begin qtick = 1'b0; tick_cnt++; end
  end

  // Driver: R4 expected quarters, MSB first, pushed once the transfer edge has passed.
  task automatic send(input logic [W-1:0] w);
    in_data  = w;
    in_valid = 1'b1;
    while (1) begin
      @(negedge clk);
      if (in_ready) break;
    end
    last_acc_q = exp_q.size();
    @(posedge clk);
    #1;
    for (int i = W - 1; i >= 0; i--) begin
      exp_q.push_back(~w[i]); exp_q.push_back(~w[i]);
      exp_q.push_back(w[i]);  exp_q.push_back(w[i]);
    end
    in_valid = 1'b0;
    in_data  = ~w;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || tx_active) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (mon_en) begin
      if (have_prev && !prev_tick) begin
        chk(line_out == p_out, "R9 line_out hold", line_out, p_out);
        chk(line_dly == p_dly, "R9 line_dly hold", line_dly, p_dly);
        chk(tx_active == p_act, "R9 tx_active hold", tx_active, p_act);
      end
      if (qtick) begin
        chk(in_ready == (exp_q.size() <= 1), "R2 ready on tick", in_ready, exp_q.size() <= 1);
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          chk(line_out == e, "R3 R4 data quarter", line_out, e);
          cur_data = 1'b1;
        end else begin
          chk(line_out == 1'b1, "R8 idle line_out", line_out, 1);
          cur_data = 1'b0;
        end
        chk(line_dly == last_out, "R5 delayed copy", line_dly, last_out);
        chk(tx_active == (cur_data || prev_data), "R6 tx_active window", tx_active, cur_data || prev_data);
        if (!tx_active) chk(line_dly == 1'b1, "R8 idle line_dly", line_dly, 1);
        last_out  = line_out;
        prev_data = cur_data;
      end else begin
        chk(in_ready == 1'b0, "R2 ready without tick", in_ready, 0);
      end
      p_out = line_out; p_dly = line_dly; p_act = tx_active;
      prev_tick = qtick;
      have_prev = 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(tx_active == 1'b0, "R1 reset tx_active", tx_active, 0);
    chk(line_out == 1'b1, "R1 reset line_out", line_out, 1);
    chk(line_dly == 1'b1, "R1 reset line_dly", line_dly, 1);
    mon_en = 1;

    send(8'hA5);
    wait_idle();

    tick_per = 1;
    send(8'h00);
    send(8'hFF);
    chk(last_acc_q == 1, "R7 accepted on last quarter", last_acc_q, 1);
    send(8'h81);
    chk(last_acc_q == 1, "R7 accepted on last quarter", last_acc_q, 1);
    wait_idle();

    tick_per = 3;
    in_valid = 1'b0;
    for (int k = 0; k < 40; k++) begin
      in_data = 8'(k * 37);
      @(negedge clk);
    end
    chk(tx_active == 1'b0, "R10 no start without valid", tx_active, 0);
    chk(line_out == 1'b1, "R10 line idle without valid", line_out, 1);

    send(8'h3C);
    send(8'hC3);
    chk(last_acc_q == 1, "R7 accepted on last quarter", last_acc_q, 1);
    wait_idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule